// File: doc/BRIEF.md
# Buffered Sector Read Controller

This block serves a host that reads from a drive-like device whose contents are kept as one contiguous raw image on an ATA-style flash store with no filesystem. The host asks for data by presenting a frame address and a count of logical sectors on a single-cycle request strobe. The block maps the frame address straight to a storage block address, then issues one or more multi-sector read commands to the storage side. It writes every returned 16-bit word into an internal buffer.

The host sees nothing until the whole request sits in the buffer. Only then does `data_ready` rise. From that point the host drains the buffer one word per read strobe, at whatever rate it likes, and never waits on the storage side. A logical sector is 2048 bytes, which is four 512-byte storage sectors. The buffer holds 64 logical sectors (128 KiB). Each storage command covers at most 248 storage sectors; any sectors left over go out in one further, shorter command.

The words per storage sector (`SUB_WORDS`) are a parameter. A production build sets it to 256, giving 1024 host words per logical sector. The default of 4 keeps the buffer small, and everything below is stated for that default: 16 host words per logical sector.

Top module: `sector_fetch_ctrl`

## Requirements
- R1: A request whose count is 0 or above 64, arriving while idle, is rejected. `err_pulse` is high in the following cycle, no storage command is issued, and `busy` stays low.
- R2: The first storage command of an accepted request carries the block address `cfg_base_lba + 4*(req_frame - cfg_frame_origin)`, taken modulo 2^28.
- R3: Every storage command covers the smaller of the sectors still outstanding and 248, and is never empty. Each later command starts at the previous address plus the previous command's sector count. The counts of one request add up to 4 times the request count. `cmd_lba` and `cmd_nsect` hold steady while `cmd_valid` waits for `cmd_ready`.
- R4: `busy` is high from the cycle after a request is accepted up to and including the cycle of the last storage word handshake, and low once that handshake has happened.
- R5: `data_ready` rises in the cycle after the last storage word is accepted. It stays high until exactly count*16 host reads have been taken, then falls, and the block is idle again and accepts a new request.
- R6: While `data_ready` is high, `host_data` shows the stored words in the order the storage side delivered them. Each cycle with `host_rd` high moves on by one word.
- R7: A request arriving while `busy` or `data_ready` is high is ignored: no extra command is issued and the running transfer is unchanged. `overrun` then goes high and stays high until reset.
- R8: `stor_ready` is high only after a command has been accepted and only until that command's count*4 words have arrived. `host_rd` pulsed while `data_ready` is low has no effect, so a later drain still starts at the first word.
- R9: Straight after reset, `busy`, `data_ready`, `cmd_valid`, `stor_ready`, `err_pulse` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_lba | input | 28 | Storage block address at which the image starts |
| cfg_frame_origin | input | 24 | Frame address that maps to `cfg_base_lba` |
| req_valid | input | 1 | Read request strobe |
| req_frame | input | 24 | Starting frame address of the request |
| req_count | input | 8 | Logical sectors requested |
| cmd_valid | output | 1 | Storage read command is pending |
| cmd_ready | input | 1 | Storage side accepts the command |
| cmd_lba | output | 28 | First storage block address of the command |
| cmd_nsect | output | 8 | Storage sectors covered by the command |
| stor_valid | input | 1 | Storage word is valid |
| stor_ready | output | 1 | Block accepts a storage word |
| stor_data | input | 16 | Storage read data word |
| host_rd | input | 1 | Host takes the word on `host_data` |
| host_data | output | 16 | Buffered word at the host read position |
| busy | output | 1 | Request is being fetched from storage |
| data_ready | output | 1 | Whole request is buffered and may be drained |
| err_pulse | output | 1 | One-cycle flag for a rejected count |
| overrun | output | 1 | Sticky flag: a request arrived while the block was occupied |

## Verification
Some rules can be checked on every cycle, and the assertions cover these:
- command fields hold steady while stalled, and each command's count lies between 1 and 248;
- only a storage handshake can raise `data_ready`;
- `busy` can only end by passing into `data_ready`;
- a rejection never starts a command;
- `overrun` never clears;
- the buffer never writes past the request or reads a word not yet written.

Other behaviour shows only through the bench's scenarios, which a behavioural model tracks cycle by cycle:
- the exact address arithmetic;
- how a request splits into 248 plus a remainder, including the exact-fit and short-remainder counts;
- the word order seen by the host;
- the exact length of the drain;
- that stray reads and clashing requests leave the transfer untouched.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef enum logic [1:0] {
      SFC_IDLE,
      SFC_ISSUE,
      SFC_FILL,
      SFC_HOLD
   } sfc_state_e;
endpackage

// File: rtl/sfc_req_decode.sv
module sfc_req_decode #(
   parameter int FRAME_W      = 24,
   parameter int LBA_W        = 28,
   parameter int CNT_W        = 8,
   parameter int MAX_SECT     = 64,
   parameter int SUB_PER_SECT = 4,
   parameter int SUB_TOT_W    = 9
) (
   input  logic [FRAME_W-1:0]   frame,
   input  logic [CNT_W-1:0]     count,
   input  logic [LBA_W-1:0]     base_lba,
   input  logic [FRAME_W-1:0]   origin,
   output logic                 count_ok,
   output logic [LBA_W-1:0]     start_lba,
   output logic [SUB_TOT_W-1:0] sub_total
);
   localparam bit POW2  = (SUB_PER_SECT & (SUB_PER_SECT - 1)) == 0;
   localparam int SHIFT = $clog2(SUB_PER_SECT);

   logic [FRAME_W-1:0] delta;
   assign delta    = frame - origin;
   assign count_ok = (count != '0) && (int'(count) <= MAX_SECT);
   assign sub_total = SUB_TOT_W'(count) * SUB_TOT_W'(SUB_PER_SECT);

   if (POW2) begin : g_shift
      assign start_lba = base_lba + (LBA_W'(delta) << SHIFT);
   end else begin : g_mult
      assign start_lba = base_lba + LBA_W'(delta) * LBA_W'(SUB_PER_SECT);
   end
endmodule

// File: rtl/sfc_chunk_seq.sv
module sfc_chunk_seq #(
   parameter int LBA_W     = 28,
   parameter int SUB_TOT_W = 9,
   parameter int NS_W      = 8,
   parameter int CW_W      = 10,
   parameter int CHUNK_MAX = 248,
   parameter int SUB_WORDS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [LBA_W-1:0]     load_lba,
   input  logic [SUB_TOT_W-1:0] load_sub,
   input  logic                 take,
   input  logic                 word,
   output logic [LBA_W-1:0]     cur_lba,
   output logic [NS_W-1:0]      cur_nsect,
   output logic                 chunk_last,
   output logic                 all_issued
);
   logic [LBA_W-1:0]     lba_q;
   logic [SUB_TOT_W-1:0] rem_q;
   logic [CW_W-1:0]      left_q;

   assign cur_lba    = lba_q;
   assign cur_nsect  = (int'(rem_q) > CHUNK_MAX) ? NS_W'(CHUNK_MAX) : NS_W'(rem_q);
   assign chunk_last = (left_q == CW_W'(1));
   assign all_issued = (rem_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lba_q  <= '0;
         rem_q  <= '0;
         left_q <= '0;
      end else if (load) begin
         lba_q  <= load_lba;
         rem_q  <= load_sub;
         left_q <= '0;
      end else if (take) begin
         lba_q  <= lba_q + LBA_W'(cur_nsect);
         rem_q  <= rem_q - SUB_TOT_W'(cur_nsect);
         left_q <= CW_W'(cur_nsect) * CW_W'(SUB_WORDS);
      end else if (word) begin
         left_q <= left_q - CW_W'(1);
      end
   end

   assert_take_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (rem_q != '0));
   assert_word_in_chunk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      word |-> (left_q != '0));
endmodule

// File: rtl/sfc_sector_buf.sv
module sfc_sector_buf #(
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 1024,
   parameter int PTR_W     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [PTR_W-1:0]  total,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last
);
   localparam int ADDR_W = $clog2(BUF_WORDS);

   logic [DATA_W-1:0] mem [BUF_WORDS];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, total_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr[ADDR_W-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         total_q <= '0;
      end else if (clear) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         total_q <= total;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + PTR_W'(1);
         if (rd_en) rd_ptr <= rd_ptr + PTR_W'(1);
      end
   end

   assign rd_data = mem[rd_ptr[ADDR_W-1:0]];
   assign rd_last = (rd_ptr == total_q - PTR_W'(1));

   assert_wr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_ptr < total_q));
   assert_rd_behind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_ptr < wr_ptr));
endmodule

// File: rtl/sector_fetch_ctrl.sv
module sector_fetch_ctrl
   import sfc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int FRAME_W      = 24,
   parameter int LBA_W        = 28,
   parameter int CNT_W        = 8,
   parameter int MAX_SECT     = 64,
   parameter int SUB_PER_SECT = 4,
   parameter int SUB_WORDS    = 4,
   parameter int CHUNK_MAX    = 248,
   localparam int NS_W        = $clog2(CHUNK_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LBA_W-1:0]   cfg_base_lba,
   input  logic [FRAME_W-1:0] cfg_frame_origin,
   input  logic               req_valid,
   input  logic [FRAME_W-1:0] req_frame,
   input  logic [CNT_W-1:0]   req_count,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic [LBA_W-1:0]   cmd_lba,
   output logic [NS_W-1:0]    cmd_nsect,
   input  logic               stor_valid,
   output logic               stor_ready,
   input  logic [DATA_W-1:0]  stor_data,
   input  logic               host_rd,
   output logic [DATA_W-1:0]  host_data,
   output logic               busy,
   output logic               data_ready,
   output logic               err_pulse,
   output logic               overrun
);
   localparam int SECT_WORDS = SUB_PER_SECT * SUB_WORDS;
   localparam int BUF_WORDS  = MAX_SECT * SECT_WORDS;
   localparam int PTR_W      = $clog2(BUF_WORDS + 1);
   localparam int SUB_TOT_W  = $clog2(MAX_SECT * SUB_PER_SECT + 1);
   localparam int CW_W       = $clog2(CHUNK_MAX * SUB_WORDS + 1);

   initial begin
      assert (CHUNK_MAX >= 1) else $error("CHUNK_MAX must be at least 1");
      assert (MAX_SECT >= 1 && MAX_SECT < (1 << CNT_W)) else $error("MAX_SECT must fit CNT_W");
      assert (SUB_PER_SECT >= 1 && SUB_WORDS >= 1) else $error("sector geometry must be nonzero");
   end

   sfc_state_e           state_q, state_d;
   logic                 count_ok, chunk_last, all_issued, rd_last;
   logic                 accept, take, word, rd_en;
   logic [LBA_W-1:0]     start_lba;
   logic [SUB_TOT_W-1:0] sub_total;
   logic                 err_q, ovr_q;

   sfc_req_decode #(
      .FRAME_W(FRAME_W), .LBA_W(LBA_W), .CNT_W(CNT_W), .MAX_SECT(MAX_SECT),
      .SUB_PER_SECT(SUB_PER_SECT), .SUB_TOT_W(SUB_TOT_W)
   ) u_decode (
      .frame(req_frame), .count(req_count), .base_lba(cfg_base_lba),
      .origin(cfg_frame_origin), .count_ok(count_ok), .start_lba(start_lba),
      .sub_total(sub_total)
   );

   assign accept = req_valid && (state_q == SFC_IDLE) && count_ok;
   assign take   = (state_q == SFC_ISSUE) && cmd_ready;
   assign word   = (state_q == SFC_FILL) && stor_valid;
   assign rd_en  = (state_q == SFC_HOLD) && host_rd;

   sfc_chunk_seq #(
      .LBA_W(LBA_W), .SUB_TOT_W(SUB_TOT_W), .NS_W(NS_W), .CW_W(CW_W),
      .CHUNK_MAX(CHUNK_MAX), .SUB_WORDS(SUB_WORDS)
   ) u_chunk (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_lba(start_lba),
      .load_sub(sub_total), .take(take), .word(word), .cur_lba(cmd_lba),
      .cur_nsect(cmd_nsect), .chunk_last(chunk_last), .all_issued(all_issued)
   );

   sfc_sector_buf #(
      .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .PTR_W(PTR_W)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .total(PTR_W'(req_count) * PTR_W'(SECT_WORDS)),
      .wr_en(word), .wr_data(stor_data), .rd_en(rd_en),
      .rd_data(host_data), .rd_last(rd_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SFC_IDLE:  if (accept) state_d = SFC_ISSUE;
         SFC_ISSUE: if (take) state_d = SFC_FILL;
         SFC_FILL:  if (word && chunk_last) state_d = all_issued ? SFC_HOLD : SFC_ISSUE;
         SFC_HOLD:  if (rd_en && rd_last) state_d = SFC_IDLE;
         default:   state_d = SFC_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SFC_IDLE;
         err_q   <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= req_valid && (state_q == SFC_IDLE) && !count_ok;
         ovr_q   <= ovr_q || (req_valid && (state_q != SFC_IDLE));
      end
   end

   assign cmd_valid  = (state_q == SFC_ISSUE);
   assign stor_ready = (state_q == SFC_FILL);
   assign busy       = (state_q == SFC_ISSUE) || (state_q == SFC_FILL);
   assign data_ready = (state_q == SFC_HOLD);
   assign err_pulse  = err_q;
   assign overrun    = ovr_q;

   assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (!busy && !cmd_valid));
   assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_lba) && $stable(cmd_nsect)));
   assert_cmd_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ((cmd_nsect != '0) && (int'(cmd_nsect) <= CHUNK_MAX)));
   assert_busy_ends_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> data_ready);
   assert_ready_after_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(stor_valid && stor_ready));
   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
endmodule

// File: tb/sector_fetch_ctrl_tb.sv
module sector_fetch_ctrl_tb;
   localparam int FRAME_W = 24;
   localparam int LBA_W   = 28;
   localparam int NS_W    = 8;
   localparam int SPS     = 4;     // storage sectors per logical sector
   localparam int SWD     = 4;     // words per storage sector
   localparam int CAP     = 248;
   localparam logic [LBA_W-1:0]   BASE   = 28'h0012000;
   localparam logic [FRAME_W-1:0] ORIGIN = 24'd45150;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic               req_valid = 0, cmd_ready = 0, stor_valid = 0, host_rd = 0;
   logic [FRAME_W-1:0] req_frame = '0;
   logic [7:0]         req_count = '0;
   logic [15:0]        stor_data = '0;
   logic               cmd_valid, stor_ready, busy, data_ready, err_pulse, overrun;
   logic [LBA_W-1:0]   cmd_lba;
   logic [NS_W-1:0]    cmd_nsect;
   logic [15:0]        host_data;

   sector_fetch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_base_lba(BASE), .cfg_frame_origin(ORIGIN),
      .req_valid(req_valid), .req_frame(req_frame), .req_count(req_count),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_lba(cmd_lba), .cmd_nsect(cmd_nsect),
      .stor_valid(stor_valid), .stor_ready(stor_ready), .stor_data(stor_data),
      .host_rd(host_rd), .host_data(host_data), .busy(busy), .data_ready(data_ready),
      .err_pulse(err_pulse), .overrun(overrun)
   );

   int n_checks = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] data_of(input longint a);
      return 16'(a * 13 + (a >> 5) + 16'h1F0);
   endfunction

   // behavioural reference model
   int          m_phase = 0, m_sub = 0, m_chunk = 0, m_total = 0, m_rd = 0;
   logic [LBA_W-1:0] m_lba = '0;
   bit          m_err = 0, m_ovr = 0;
   logic [15:0] m_exp [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_err = 0; m_ovr = 0; m_rd = 0;
      end else begin
         m_err = 0;
         if (req_valid && m_phase != 0) m_ovr = 1;
         case (m_phase)
            0: if (req_valid) begin
                  if (req_count != 0 && req_count <= 64) begin
                     m_phase = 1;
                     m_lba   = BASE + LBA_W'(SPS * longint'(FRAME_W'(req_frame - ORIGIN)));
                     m_sub   = req_count * SPS;
                     m_total = req_count * SPS * SWD;
                     m_rd    = 0;
                     m_exp.delete();
                  end else m_err = 1;
               end
            1: if (cmd_ready) begin
                  int n;
                  n = (m_sub > CAP) ? CAP : m_sub;
                  m_lba = m_lba + LBA_W'(n);
                  m_sub = m_sub - n;
                  m_chunk = n * SWD;
                  m_phase = 2;
               end
            2: if (stor_valid) begin
                  m_chunk--;
                  if (m_chunk == 0) m_phase = (m_sub == 0) ? 3 : 1;
               end
            3: if (host_rd) begin
                  m_rd++;
                  if (m_rd == m_total) m_phase = 0;
               end
            default: m_phase = 0;
         endcase
      end
   end

   // storage responder and per-cycle comparison
   int cyc = 0;
   logic [15:0]      sq [$];
   logic [LBA_W-1:0] log_lba [$];
   int               log_ns [$];

   always @(negedge clk) begin
      bit r;
      cyc++;
      if (rst_n) begin
         chk(busy == (m_phase == 1 || m_phase == 2), "R4 busy", busy, m_phase);
         chk(data_ready == (m_phase == 3), "R5 data_ready", data_ready, m_phase);
         chk(cmd_valid == (m_phase == 1), "R3 cmd_valid", cmd_valid, m_phase);
         chk(stor_ready == (m_phase == 2), "R8 stor_ready", stor_ready, m_phase);
         chk(err_pulse == m_err, "R1 err_pulse", err_pulse, m_err);
         chk(overrun == m_ovr, "R7 overrun", overrun, m_ovr);
         if (m_phase == 1) begin
            chk(cmd_lba == m_lba, "R2 cmd_lba", cmd_lba, m_lba);
            chk(int'(cmd_nsect) == ((m_sub > CAP) ? CAP : m_sub), "R3 cmd_nsect",
                cmd_nsect, (m_sub > CAP) ? CAP : m_sub);
         end
         if (m_phase == 3 && m_rd < m_exp.size())
            chk(host_data == m_exp[m_rd], "R6 host_data", host_data, m_exp[m_rd]);
         r = (cyc % 3 != 0);
         if (cmd_valid && r) begin
            log_lba.push_back(cmd_lba);
            log_ns.push_back(int'(cmd_nsect));
            for (int k = 0; k < int'(cmd_nsect) * SWD; k++)
               sq.push_back(data_of(longint'(cmd_lba) * SWD + k));
         end
         cmd_ready = r;
         if (sq.size() > 0 && (cyc % 5 != 2)) begin
            stor_valid = 1;
            stor_data  = sq[0];
            if (stor_ready) begin
               m_exp.push_back(sq[0]);
               void'(sq.pop_front());
            end
         end else stor_valid = 0;
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cyc > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic send(input int off, input int cnt);
      req_valid = 1;
      req_frame = ORIGIN + FRAME_W'(off);
      req_count = 8'(cnt);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain(input logic [15:0] first_exp, output int nrd);
      int i = 0;
      nrd = 0;
      while (m_phase != 3) @(negedge clk);
      chk(host_data == first_exp, "R6 first word", host_data, first_exp);
      while (m_phase == 3) begin
         host_rd = (i % 4 != 3);
         if (host_rd) nrd++;
         i++;
         @(negedge clk);
      end
      host_rd = 0;
   endtask

   initial begin
      int nrd;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !data_ready && !cmd_valid && !stor_ready && !err_pulse && !overrun,
          "R9 reset outputs", {busy, data_ready, cmd_valid, stor_ready, err_pulse, overrun}, 0);

      // R1: zero count, then over-limit count
      send(10, 0);
      chk(err_pulse == 1, "R1 zero count err", err_pulse, 1);
      @(negedge clk);
      chk(err_pulse == 0 && !busy && !cmd_valid, "R1 err one cycle, no cmd", {err_pulse, busy}, 0);
      send(10, 65);
      chk(err_pulse == 1, "R1 count 65 err", err_pulse, 1);
      repeat (3) @(negedge clk);
      chk(log_lba.size() == 0, "R1 no command issued", log_lba.size(), 0);

      // R2/R4/R5: small request
      send(10, 3);
      chk(busy == 1, "R4 busy after accept", busy, 1);
      while (!cmd_valid) @(negedge clk);
      chk(cmd_lba == BASE + 28'd40, "R2 first lba", cmd_lba, BASE + 28'd40);
      drain(data_of(longint'(BASE + 28'd40) * SWD), nrd);
      chk(nrd == 3 * 16, "R5 drain length 3", nrd, 48);
      chk(log_ns.size() == 1 && log_ns[0] == 12, "R3 single cmd of 12", log_ns.size(), 1);

      // R3/R7/R8: full request split 248 + 8, with clash and stray reads
      log_lba.delete(); log_ns.delete();
      send(20, 64);
      repeat (30) @(negedge clk);
      host_rd = 1;
      repeat (3) @(negedge clk);
      host_rd = 0;
      send(3, 5);
      chk(overrun == 1, "R7 overrun set", overrun, 1);
      drain(data_of(longint'(BASE + 28'd80) * SWD), nrd);
      chk(nrd == 1024, "R5 drain length 64", nrd, 1024);
      chk(log_ns.size() == 2, "R7 clash adds no command", log_ns.size(), 2);
      if (log_ns.size() == 2) begin
         chk(log_ns[0] == 248 && log_ns[1] == 8, "R3 split 248+8", log_ns[1], 8);
         chk(log_lba[1] == log_lba[0] + 28'd248, "R3 contiguous lba", log_lba[1], log_lba[0] + 28'd248);
      end
      chk(overrun == 1, "R7 overrun sticky", overrun, 1);

      // R3: exact fit and short remainder
      log_lba.delete(); log_ns.delete();
      send(0, 62);
      drain(data_of(longint'(BASE) * SWD), nrd);
      chk(log_ns.size() == 1 && log_ns[0] == 248, "R3 exact 248", log_ns.size(), 1);
      log_lba.delete(); log_ns.delete();
      send(100, 63);
      drain(data_of(longint'(BASE + 28'd400) * SWD), nrd);
      chk(log_ns.size() == 2 && log_ns[1] == 4, "R3 split 248+4", log_ns.size(), 2);

      // R5: idle again, single sector
      send(1, 1);
      drain(data_of(longint'(BASE + 28'd4) * SWD), nrd);
      chk(nrd == 16, "R5 drain length 1", nrd, 16);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule